// File: doc/BRIEF.md
# NAND Bus Cycle Timing Sequencer

This block turns single host read or write requests into strobe cycles on a NAND flash bus. It drives an active-low chip enable, an active-low write strobe, an active-low read strobe, a write data bus with its drive enable, and a busy flag. Every access passes through the same fixed sequence of phases: setup, then strobe (wait), then hold. The length of each phase is programmable.

Two independent sets of phase counts are provided. One is for the common memory space and one is for the attribute memory space. A space-select bit sent with each request chooses which set times that access. This lets a long hold, such as one sized to cover the device's write-to-busy delay after the final address byte, apply only to accesses sent to the attribute space. Ordinary data transfers in the common space then keep a short hold.

The host holds `req_valid` until the sequencer takes the request. A request is taken on a rising clock edge while the sequencer is idle. `req_ready` pulses for one cycle to mark the last cycle of the access.

Top module: `nand_cycle_seq`

## Requirements
- R1: After reset the sequencer is idle. In that state `nand_ce_n`, `nand_we_n` and `nand_oe_n` are 1, and `nand_dout_en`, `busy` and `req_ready` are 0.
- R2: The setup phase starts on the first cycle after acceptance and lasts setup+1 cycles. During it `nand_ce_n` is 0 and both strobes are 1.
- R3: The wait phase follows setup and lasts wait+1 cycles. During it exactly one strobe is 0: `nand_we_n` for a write (`req_write`=1) or `nand_oe_n` for a read. The two strobes are never 0 together.
- R4: The hold phase follows the wait phase and lasts hold+1 cycles with both strobes at 1. `nand_ce_n` stays 0 from the first setup cycle through the last hold cycle.
- R5: A request with `req_attr`=1 is timed by the `att_*` counts. A request with `req_attr`=0 is timed by the `cmn_*` counts, whatever the values of the other set.
- R6: The counts of the selected set are captured when the request is accepted. Changing any timing input during the access does not change that access's phase lengths.
- R7: `req_ready` is 1 for exactly one cycle, the last hold cycle. `busy` is 1 in every cycle in which `nand_ce_n` is 0.
- R8: A request is accepted only while idle. A `req_valid` pulse that begins and ends while an access is in progress starts no further access.
- R9: For a write, `nand_dout_en` is 1 from the first setup cycle through the last hold cycle, and `nand_dout` holds the write data captured at acceptance. For a read, `nand_dout_en` stays 0.
- R10: With `req_valid` held high, a new access starts after exactly one idle cycle. That access may be in a different space and in the other direction from the one before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request, held until accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_attr | input | 1 | 1 = attribute space timing, 0 = common space timing |
| req_wdata | input | DATA_W | Write data |
| cmn_setup | input | CNT_W | Common space setup count |
| cmn_wait | input | CNT_W | Common space strobe count |
| cmn_hold | input | CNT_W | Common space hold count |
| att_setup | input | CNT_W | Attribute space setup count |
| att_wait | input | CNT_W | Attribute space strobe count |
| att_hold | input | CNT_W | Attribute space hold count |
| req_ready | output | 1 | One-cycle pulse on the last cycle of an access |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_oe_n | output | 1 | Read strobe, active low |
| nand_dout | output | DATA_W | Write data driven to the bus |
| nand_dout_en | output | 1 | Data bus drive enable |
| busy | output | 1 | Access in progress |

## Verification
Two events can fall on the same cycle boundary: the end of one access's hold (the `req_ready` pulse) and the acceptance of the next request. In that cycle the timing set must also switch from one space to the other. The bench provokes this by holding `req_valid` high across two accesses and flipping `req_attr` and `req_write` on the single idle cycle between them. It then checks three things: that exactly one idle cycle separates the accesses, that the second access is timed entirely by its own space's counts, and that it uses the strobe for its own direction. A second collision is a timing input changing while an access is already running. The bench rewrites the active set's counts during the setup phase and expects the phase lengths captured at acceptance.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_WAIT  = 2'd2,
      PH_HOLD  = 2'd3
   } nand_phase_e;

   localparam int NUM_FIELDS = 3;
   localparam int FLD_HOLD   = 0;
   localparam int FLD_WAIT   = 1;
   localparam int FLD_SETUP  = 2;

endpackage

// File: rtl/nand_tset_sel.sv
module nand_tset_sel
   import nand_seq_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             attr,
   input  logic [CNT_W-1:0] cmn_setup,
   input  logic [CNT_W-1:0] cmn_wait,
   input  logic [CNT_W-1:0] cmn_hold,
   input  logic [CNT_W-1:0] att_setup,
   input  logic [CNT_W-1:0] att_wait,
   input  logic [CNT_W-1:0] att_hold,
   output logic [CNT_W-1:0] live_setup,
   output logic [CNT_W-1:0] lat_wait,
   output logic [CNT_W-1:0] lat_hold
);

   localparam int NLAT = NUM_FIELDS - 1;

   logic [NUM_FIELDS-1:0][CNT_W-1:0] cmn_f, att_f, live_f;
   logic [NLAT-1:0][CNT_W-1:0]       lat_f;

   assign cmn_f = {cmn_setup, cmn_wait, cmn_hold};
   assign att_f = {att_setup, att_wait, att_hold};

   for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_sel
      assign live_f[f] = attr ? att_f[f] : cmn_f[f];
   end

   for (genvar f = 0; f < NLAT; f++) begin : g_lat
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    lat_f[f] <= '0;
         else if (load) lat_f[f] <= live_f[f];
      end
   end

   assign live_setup = live_f[FLD_SETUP];
   assign lat_wait   = lat_f[FLD_WAIT];
   assign lat_hold   = lat_f[FLD_HOLD];

endmodule

// File: rtl/nand_phase_ctr.sv
module nand_phase_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             cnt_zero
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
   import nand_seq_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic              req_attr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [CNT_W-1:0]  cmn_setup,
   input  logic [CNT_W-1:0]  cmn_wait,
   input  logic [CNT_W-1:0]  cmn_hold,
   input  logic [CNT_W-1:0]  att_setup,
   input  logic [CNT_W-1:0]  att_wait,
   input  logic [CNT_W-1:0]  att_hold,
   output logic              req_ready,
   output logic              nand_ce_n,
   output logic              nand_we_n,
   output logic              nand_oe_n,
   output logic [DATA_W-1:0] nand_dout,
   output logic              nand_dout_en,
   output logic              busy
);

   if (DATA_W != 8 && DATA_W != 16) begin : g_bad_data_w
      $error("nand_cycle_seq: DATA_W must be 8 or 16");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt_w
      $error("nand_cycle_seq: CNT_W must lie in 1..16");
   end

   nand_phase_e       phase_q, phase_d;
   logic              wr_q;
   logic [DATA_W-1:0] wdata_q;
   logic              accept;
   logic              ctr_load;
   logic [CNT_W-1:0]  ctr_val;
   logic              cnt_zero;
   logic [CNT_W-1:0]  live_setup, lat_wait, lat_hold;

   assign accept = (phase_q == PH_IDLE) && req_valid;

   nand_tset_sel #(.CNT_W(CNT_W)) u_tset (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .attr       (req_attr),
      .cmn_setup  (cmn_setup),
      .cmn_wait   (cmn_wait),
      .cmn_hold   (cmn_hold),
      .att_setup  (att_setup),
      .att_wait   (att_wait),
      .att_hold   (att_hold),
      .live_setup (live_setup),
      .lat_wait   (lat_wait),
      .lat_hold   (lat_hold)
   );

   nand_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctr_load),
      .load_val (ctr_val),
      .cnt_zero (cnt_zero)
   );

   always_comb begin
      phase_d  = phase_q;
      ctr_load = 1'b0;
      ctr_val  = live_setup;
      unique case (phase_q)
         PH_IDLE: begin
            if (req_valid) begin
               phase_d  = PH_SETUP;
               ctr_load = 1'b1;
               ctr_val  = live_setup;
            end
         end
         PH_SETUP: begin
            if (cnt_zero) begin
               phase_d  = PH_WAIT;
               ctr_load = 1'b1;
               ctr_val  = lat_wait;
            end
         end
         PH_WAIT: begin
            if (cnt_zero) begin
               phase_d  = PH_HOLD;
               ctr_load = 1'b1;
               ctr_val  = lat_hold;
            end
         end
         PH_HOLD: begin
            if (cnt_zero) phase_d = PH_IDLE;
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         wr_q    <= 1'b0;
         wdata_q <= '0;
      end else begin
         phase_q <= phase_d;
         if (accept) begin
            wr_q    <= req_write;
            wdata_q <= req_wdata;
         end
      end
   end

   assign busy         = (phase_q != PH_IDLE);
   assign nand_ce_n    = ~busy;
   assign nand_we_n    = ~((phase_q == PH_WAIT) && wr_q);
   assign nand_oe_n    = ~((phase_q == PH_WAIT) && !wr_q);
   assign nand_dout_en = busy && wr_q;
   assign nand_dout    = wdata_q;
   assign req_ready    = (phase_q == PH_HOLD) && cnt_zero;

endmodule

// File: rtl/nand_cycle_seq_chk.sv
module nand_cycle_seq_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              nand_ce_n,
   input logic              nand_we_n,
   input logic              nand_oe_n,
   input logic [DATA_W-1:0] nand_dout,
   input logic              nand_dout_en,
   input logic              busy
);

   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_oe_n)); // R3

   AST_STROBE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_oe_n) |-> !nand_ce_n); // R4

   AST_SETUP_LEADS_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(nand_we_n) |-> $past(!nand_ce_n)); // R2

   AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |-> !nand_ce_n); // R4

   AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> !req_ready); // R7

   AST_READY_ENDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |=> nand_ce_n); // R10

   AST_BUSY_MATCH_CE: assert property (@(posedge clk) disable iff (!rst_n)
      busy == !nand_ce_n); // R7

   AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (nand_ce_n && req_valid) |=> !nand_ce_n); // R8

   AST_DRIVE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      nand_dout_en |-> (!nand_ce_n && nand_oe_n)); // R9

   AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (nand_dout_en && $past(nand_dout_en)) |-> $stable(nand_dout)); // R9

endmodule

bind nand_cycle_seq nand_cycle_seq_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/nand_cycle_seq_tb.sv
`timescale 1ns/1ps
module nand_cycle_seq_tb_top;

   localparam int DW = 16;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic          req_attr = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic [CW-1:0] cmn_setup = 8'd2, cmn_wait = 8'd3, cmn_hold = 8'd1;
   logic [CW-1:0] att_setup = 8'd1, att_wait = 8'd2, att_hold = 8'd40;
   logic          req_ready, nand_ce_n, nand_we_n, nand_oe_n, nand_dout_en, busy;
   logic [DW-1:0] nand_dout;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   nand_cycle_seq #(.DATA_W(DW), .CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_attr(req_attr), .req_wdata(req_wdata),
      .cmn_setup(cmn_setup), .cmn_wait(cmn_wait), .cmn_hold(cmn_hold),
      .att_setup(att_setup), .att_wait(att_wait), .att_hold(att_hold),
      .req_ready(req_ready), .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n),
      .nand_oe_n(nand_oe_n), .nand_dout(nand_dout), .nand_dout_en(nand_dout_en),
      .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Starts at a negedge inside the first setup cycle; returns at the first idle negedge.
   task automatic measure(input bit exp_wr, input logic [DW-1:0] exp_data,
                          output int s, output int w, output int h, output int bad);
      int  stage = 0;
      int  n = 0;
      bit  last_rdy = 1'b0;
      bit  strobe, other;
      s = 0; w = 0; h = 0; bad = 0;
      while (nand_ce_n == 1'b0 && n < 4000) begin
         strobe = exp_wr ? !nand_we_n : !nand_oe_n;
         other  = exp_wr ? !nand_oe_n : !nand_we_n;
         if (other) bad++;
         if (strobe) begin
            if (stage == 2) bad++;
            stage = 1; w++;
         end else if (stage == 0) s++;
         else begin stage = 2; h++; end
         if (nand_dout_en !== exp_wr) bad++;
         if (exp_wr && nand_dout !== exp_data) bad++;
         if (!busy) bad++;
         if (last_rdy) bad++;
         last_rdy = req_ready;
         n++;
         @(negedge clk);
      end
      if (!last_rdy) bad++;
      if (busy || req_ready) bad++;
   endtask

   task automatic launch(input bit wr, input bit attr, input logic [DW-1:0] data);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_attr = attr; req_wdata = data;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(nand_ce_n && nand_we_n && nand_oe_n, "R1", "strobes idle",
          {nand_ce_n, nand_we_n, nand_oe_n}, 7);
      chk(!nand_dout_en && !busy && !req_ready, "R1", "en/busy/ready idle",
          {nand_dout_en, busy, req_ready}, 0);
   endtask

   task automatic t_single(input bit wr, input bit attr, input logic [DW-1:0] data,
                           input string tag);
      int s, w, h, bad, es, ew, eh;
      es = attr ? att_setup : cmn_setup;
      ew = attr ? att_wait  : cmn_wait;
      eh = attr ? att_hold  : cmn_hold;
      launch(wr, attr, data);
      measure(wr, data, s, w, h, bad);
      chk(s == es + 1, "R2", {tag, " setup cycles"}, s, es + 1);
      chk(w == ew + 1, "R3", {tag, " strobe cycles"}, w, ew + 1);
      chk(h == eh + 1, "R4", {tag, " hold cycles"}, h, eh + 1);
      chk(bad == 0, "R9", {tag, " strobe/drive/ready shape (R7)"}, bad, 0);
   endtask

   task automatic t_space_select;
      // R5: attribute set chosen by req_attr, common set otherwise
      t_single(1'b1, 1'b1, 16'hA55A, "R5 attr write");
      t_single(1'b0, 1'b1, 16'h0000, "R5 attr read");
      t_single(1'b1, 1'b0, 16'h1234, "R5 common write");
      t_single(1'b0, 1'b0, 16'h0000, "R5 common read");
   endtask

   task automatic t_zero;
      logic [CW-1:0] keep [6];
      keep = '{cmn_setup, cmn_wait, cmn_hold, att_setup, att_wait, att_hold};
      @(negedge clk);
      cmn_setup = 0; cmn_wait = 0; cmn_hold = 0;
      att_setup = 0; att_wait = 0; att_hold = 0;
      t_single(1'b1, 1'b0, 16'hFFFF, "zero write");
      t_single(1'b0, 1'b1, 16'h0000, "zero read");
      cmn_setup = keep[0]; cmn_wait = keep[1]; cmn_hold = keep[2];
      att_setup = keep[3]; att_wait = keep[4]; att_hold = keep[5];
   endtask

   task automatic t_latch;
      int s, w, h, bad;
      launch(1'b1, 1'b0, 16'h5A5A);
      cmn_setup = 8'd9; cmn_wait = 8'd9; cmn_hold = 8'd9;
      measure(1'b1, 16'h5A5A, s, w, h, bad);
      chk(s == 3, "R6", "setup after mid-access change", s, 3);
      chk(w == 4, "R6", "strobe after mid-access change", w, 4);
      chk(h == 2, "R6", "hold after mid-access change", h, 2);
      chk(bad == 0, "R6", "shape", bad, 0);
      cmn_setup = 8'd2; cmn_wait = 8'd3; cmn_hold = 8'd1;
   endtask

   task automatic t_busy_ignore;
      int idle_seen = 0;
      int n = 0;
      launch(1'b0, 1'b1, 16'h0000);
      @(negedge clk);
      req_valid = 1'b1; req_attr = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      while (!nand_ce_n && n < 4000) begin n++; @(negedge clk); end
      for (int i = 0; i < 6; i++) begin
         if (nand_ce_n) idle_seen++;
         @(negedge clk);
      end
      chk(idle_seen == 6, "R8", "idle cycles after busy-time pulse", idle_seen, 6);
   endtask

   task automatic t_back_to_back;
      int s, w, h, bad;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_attr = 1'b0; req_wdata = 16'hC3C3;
      @(negedge clk);
      measure(1'b1, 16'hC3C3, s, w, h, bad);
      chk(s == 3 && w == 4 && h == 2 && bad == 0, "R10", "first access (common write)",
          s * 100 + w * 10 + h, 342);
      req_write = 1'b0; req_attr = 1'b1;
      chk(nand_ce_n == 1'b1, "R10", "idle gap cycle", nand_ce_n, 1);
      @(negedge clk);
      req_valid = 1'b0;
      chk(nand_ce_n == 1'b0, "R10", "second access starts after one idle", nand_ce_n, 0);
      measure(1'b0, 16'h0000, s, w, h, bad);
      chk(s == 2, "R5", "switched access setup", s, 2);
      chk(w == 3, "R5", "switched access strobe", w, 3);
      chk(h == 41, "R5", "switched access long hold", h, 41);
      chk(bad == 0, "R10", "switched access shape", bad, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_space_select();
      t_zero();
      t_latch();
      t_busy_ignore();
      t_back_to_back();
      repeat (3) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule